// File: doc/BRIEF.md
# Real-Time Clock Host Register Bank

This block is the host-facing register bank of a real-time clock. It sits between a simple synchronous byte-wide register bus and an external calendar counter. The counter advances on a 32.768 kHz tick and presents its seven time fields to this block. The block holds the control, status, interrupt-enable and alarm registers. It forwards host writes of the time fields to the counter, and it tells the counter whether to run.

The host reads the time in one of two ways. It can read the live fields directly. It can also request a snapshot: setting the get-time control bit makes the block copy all seven live fields into shadow registers on the next tick. With the read-select bit set, time reads return that frozen copy, so a multi-byte read cannot tear across a seconds rollover.

On a tick while the clock runs, an alarm comparator matches six alarm fields (seconds to year) against the live time. A match sets a sticky alarm flag in the status register. The host clears that flag by writing 1 to it, and the interrupt output is the flag gated by its enable bit.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, control reads 0x00, interrupt-enable reads 0x00, status reads 0x01 (running, no alarm), the shadow time fields are all zero and `alarm_irq` is low.
- R2: Control register (0x10) stores only bit 0 (stop), bit 6 (get-time) and bit 7 (read-select); all other bits read as 0.
- R3: While control bit 0 is 1, `cal_run` is low, status bit 0 reads 0 and no alarm is raised; while it is 0, `cal_run` is high and status bit 0 reads 1.
- R4: A 0-to-1 change of control bit 6, sampled on a tick, loads all seven live fields into the shadow registers at that tick; nothing is loaded before the tick, and holding the bit at 1 across further ticks does not reload.
- R5: With control bit 7 at 1, reads of addresses 0x00..0x06 return the shadow fields; with it at 0 they return the live fields.
- R6: The time fields occupy 0x00..0x06 in the order seconds, minutes, hours, day, month, year, weekday (live byte i is `live_time[8i+7:8i]`). A bus write there drives `cal_wr_en`, `cal_wr_idx` and `cal_wr_data` in the same cycle. Alarm fields seconds..year occupy 0x08..0x0D and are read/write. Interrupt-enable is at 0x12 and status is at 0x11. Unmapped addresses read 0x00.
- R7: On a tick while running, if all six alarm fields equal the live seconds..year fields, status bit 6 is set; weekday is not compared, and no tick means no match.
- R8: Writing status with bit 6 at 1 clears the alarm flag, and writing with bit 6 at 0 leaves it unchanged. Status bit 0 is read-only, so writing 0xFE clears every flag but bit 0. A match in the same cycle as a clear keeps the flag set.
- R9: Interrupt-enable stores only bit 3 (other bits read 0), and `alarm_irq` equals status bit 6 AND that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| live_time | input | 56 | Live calendar fields from the counter, seconds in the low byte |
| cal_run | output | 1 | High when the counter may advance |
| cal_wr_en | output | 1 | Host is writing a time field this cycle |
| cal_wr_idx | output | 3 | Time field being written (0 = seconds) |
| cal_wr_data | output | 8 | Value for that field |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The embedded assertions check on every cycle that the shadow copy changes only on a tick, that a detected get-time edge loads exactly the live value of that cycle, that the alarm flag rises only on a running tick with a full match, that it falls only after a status write with bit 6 set, and that a stop write drops `cal_run`. Only the bench scenarios can show that the shadow holds still when get-time stays high over several ticks, that weekday is excluded from the match, that the read-select mux picks the right source per address, and that a simultaneous match and clear leaves the flag set.

// File: rtl/rtc_regbank_pkg.sv
// Shared constants for the RTC register bank: address map and bit positions.
// Assumes a 5-bit byte address space and 8-bit registers.
package rtc_regbank_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned BYTE_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_TIME_BASE = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_ALM_BASE  = 5'h08;
    localparam logic [ADDR_W-1:0] ADDR_CTRL      = 5'h10;
    localparam logic [ADDR_W-1:0] ADDR_STAT      = 5'h11;
    localparam logic [ADDR_W-1:0] ADDR_IEN       = 5'h12;

    localparam int unsigned CTRL_STOP_BIT = 0;
    localparam int unsigned CTRL_GET_BIT  = 6;
    localparam int unsigned CTRL_RSEL_BIT = 7;
    localparam int unsigned STAT_RUN_BIT  = 0;
    localparam int unsigned STAT_ALM_BIT  = 6;
    localparam int unsigned IEN_ALM_BIT   = 3;
endpackage

// File: rtl/rtc_snapshot.sv
// Shadow copy of the time fields. The get-time request is sampled on each
// tick; a 0-to-1 change seen there loads the live fields on that same tick.
// Assumes tick is a single-cycle strobe in the clk domain.
module rtc_snapshot #(
    parameter int unsigned NUM_FIELDS = 7,
    parameter int unsigned FIELD_W    = 8,
    localparam int unsigned VEC_W     = NUM_FIELDS * FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             get_req,
    input  logic [VEC_W-1:0] live,
    output logic [VEC_W-1:0] shadow
);
    logic             get_seen_q;
    logic [VEC_W-1:0] shadow_q;

    // Edge detect of the request in tick time, and shadow load on that edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            get_seen_q <= 1'b0;
            shadow_q   <= '0;
        end else if (tick) begin
            get_seen_q <= get_req;
            if (get_req && !get_seen_q) shadow_q <= live;
        end
    end

    assign shadow = shadow_q;

    // R4: shadow never moves between ticks.
    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(shadow_q));
    // R4: a detected edge captures the live value of that cycle.
    assert_shadow_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && get_req && !get_seen_q) |=> (shadow_q == $past(live)));
endmodule

// File: rtl/rtc_alarm.sv
// Alarm field registers, tick-time comparator and the sticky alarm flag.
// Assumes the caller supplies only the compared live fields (seconds..year).
// A match and a clear in the same cycle leave the flag set.
module rtc_alarm #(
    parameter int unsigned NUM_FIELDS = 6,
    parameter int unsigned FIELD_W    = 8,
    localparam int unsigned VEC_W     = NUM_FIELDS * FIELD_W,
    localparam int unsigned IDX_W     = $clog2(NUM_FIELDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               run,
    input  logic [VEC_W-1:0]   live,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic               clr_req,
    output logic [VEC_W-1:0]   alm_fields,
    output logic               flag
);
    logic [NUM_FIELDS-1:0] field_eq;
    logic                  match_all;
    logic                  flag_q;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        logic [FIELD_W-1:0] alm_q;
        // Host-writable alarm field i.
        always_ff @(posedge clk) begin
            if (!rst_n)                                     alm_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))         alm_q <= wr_data;
        end
        assign field_eq[i] = (alm_q == live[i*FIELD_W +: FIELD_W]);
        assign alm_fields[i*FIELD_W +: FIELD_W] = alm_q;
    end

    assign match_all = &field_eq;

    // Sticky flag: set on a running tick with a full match, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        flag_q <= 1'b0;
        else if (tick && run && match_all) flag_q <= 1'b1;
        else if (clr_req)                  flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R7: the flag rises only from a running tick with every field equal.
    assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick && run && match_all));
    // R8: the flag falls only after a write-one-to-clear request.
    assert_flag_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(clr_req));
endmodule

// File: rtl/rtc_regbank.sv
// Host register bank of the RTC: control, status, interrupt enable, alarm
// and time access. Time writes go straight to the external counter; time
// reads come from the live fields or the shadow copy per read-select.
// Assumes bus_addr is stable while bus_rdata is sampled.
module rtc_regbank
    import rtc_regbank_pkg::*;
#(
    parameter int unsigned NUM_TIME  = 7,
    parameter int unsigned NUM_ALARM = 6,
    localparam int unsigned TIME_W   = NUM_TIME * BYTE_W,
    localparam int unsigned ALM_W    = NUM_ALARM * BYTE_W,
    localparam int unsigned TIME_IW  = $clog2(NUM_TIME),
    localparam int unsigned ALM_IW   = $clog2(NUM_ALARM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [TIME_W-1:0]   live_time,
    output logic                cal_run,
    output logic                cal_wr_en,
    output logic [TIME_IW-1:0]  cal_wr_idx,
    output logic [BYTE_W-1:0]   cal_wr_data,
    output logic                alarm_irq
);
    logic stop_q, get_q, rsel_q, ien_q;
    logic in_time, in_alm, wr_ctrl, wr_ien, clr_req, alm_flag;
    logic [TIME_IW-1:0] t_idx;
    logic [ALM_IW-1:0]  a_idx;
    logic [TIME_W-1:0]  shadow;
    logic [ALM_W-1:0]   alm_fields;
    logic [BYTE_W-1:0]  time_val, alm_val;

    // Address decode.
    assign in_time = (bus_addr >= ADDR_TIME_BASE) && (bus_addr < ADDR_TIME_BASE + ADDR_W'(NUM_TIME));
    assign in_alm  = (bus_addr >= ADDR_ALM_BASE)  && (bus_addr < ADDR_ALM_BASE  + ADDR_W'(NUM_ALARM));
    assign t_idx   = TIME_IW'(bus_addr - ADDR_TIME_BASE);
    assign a_idx   = ALM_IW'(bus_addr - ADDR_ALM_BASE);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_ien  = bus_wr && (bus_addr == ADDR_IEN);
    assign clr_req = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[STAT_ALM_BIT];

    // Control and interrupt-enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            get_q  <= 1'b0;
            rsel_q <= 1'b0;
            ien_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                stop_q <= bus_wdata[CTRL_STOP_BIT];
                get_q  <= bus_wdata[CTRL_GET_BIT];
                rsel_q <= bus_wdata[CTRL_RSEL_BIT];
            end
            if (wr_ien) ien_q <= bus_wdata[IEN_ALM_BIT];
        end
    end

    assign cal_run     = ~stop_q;
    assign cal_wr_en   = bus_wr && in_time;
    assign cal_wr_idx  = t_idx;
    assign cal_wr_data = bus_wdata;
    assign alarm_irq   = alm_flag && ien_q;

    rtc_snapshot #(.NUM_FIELDS(NUM_TIME), .FIELD_W(BYTE_W)) u_snap (
        .clk(clk), .rst_n(rst_n), .tick(tick), .get_req(get_q),
        .live(live_time), .shadow(shadow)
    );

    rtc_alarm #(.NUM_FIELDS(NUM_ALARM), .FIELD_W(BYTE_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(cal_run),
        .live(live_time[ALM_W-1:0]), .wr_en(bus_wr && in_alm),
        .wr_idx(a_idx), .wr_data(bus_wdata), .clr_req(clr_req),
        .alm_fields(alm_fields), .flag(alm_flag)
    );

    // Pick the addressed time field from the selected source.
    always_comb begin
        time_val = '0;
        for (int i = 0; i < NUM_TIME; i++)
            if (t_idx == TIME_IW'(i))
                time_val = rsel_q ? shadow[i*BYTE_W +: BYTE_W] : live_time[i*BYTE_W +: BYTE_W];
    end

    // Pick the addressed alarm field.
    always_comb begin
        alm_val = '0;
        for (int i = 0; i < NUM_ALARM; i++)
            if (a_idx == ALM_IW'(i)) alm_val = alm_fields[i*BYTE_W +: BYTE_W];
    end

    // Read data mux over the whole map.
    always_comb begin
        bus_rdata = '0;
        if (in_time)                     bus_rdata = time_val;
        else if (in_alm)                 bus_rdata = alm_val;
        else if (bus_addr == ADDR_CTRL) begin
            bus_rdata[CTRL_STOP_BIT] = stop_q;
            bus_rdata[CTRL_GET_BIT]  = get_q;
            bus_rdata[CTRL_RSEL_BIT] = rsel_q;
        end else if (bus_addr == ADDR_STAT) begin
            bus_rdata[STAT_RUN_BIT]  = cal_run;
            bus_rdata[STAT_ALM_BIT]  = alm_flag;
        end else if (bus_addr == ADDR_IEN) bus_rdata[IEN_ALM_BIT] = ien_q;
    end

    // R3: a stop write halts the counter from the next cycle.
    assert_stop_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[CTRL_STOP_BIT]) |=> !cal_run);
    // R6: time writes are forwarded only for time addresses.
    assert_fwd_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_wr_en |-> (bus_wr && (bus_addr < ADDR_W'(NUM_TIME))));
endmodule

// File: tb/rtc_regbank_bench.sv
module rtc_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [55:0] live_time = 56'h36_35_34_33_32_31_30;
    logic        cal_run, cal_wr_en, alarm_irq;
    logic [2:0]  cal_wr_idx;
    logic [7:0]  cal_wr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regbank u_rtc_regbank (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .live_time(live_time), .cal_run(cal_run), .cal_wr_en(cal_wr_en),
        .cal_wr_idx(cal_wr_idx), .cal_wr_data(cal_wr_data), .alarm_irq(alarm_irq)
    );

    // {write, addr, data, expected read, requirement number}
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 5'h08, 8'h59, 8'h00, 4'd6}, {1'b0, 5'h08, 8'h00, 8'h59, 4'd6}, // R6 alarm sec
        {1'b1, 5'h0D, 8'h24, 8'h00, 4'd6}, {1'b0, 5'h0D, 8'h00, 8'h24, 4'd6}, // R6 alarm year
        {1'b1, 5'h0A, 8'h07, 8'h00, 4'd6}, {1'b0, 5'h0A, 8'h00, 8'h07, 4'd6},
        {1'b1, 5'h12, 8'hFF, 8'h00, 4'd9}, {1'b0, 5'h12, 8'h00, 8'h08, 4'd9}, // R9 only bit 3
        {1'b1, 5'h12, 8'h00, 8'h00, 4'd9}, {1'b0, 5'h12, 8'h00, 8'h00, 4'd9},
        {1'b1, 5'h10, 8'hFF, 8'h00, 4'd2}, {1'b0, 5'h10, 8'h00, 8'hC1, 4'd2}, // R2 mask
        {1'b1, 5'h10, 8'h00, 8'h00, 4'd2}, {1'b0, 5'h10, 8'h00, 8'h00, 4'd2},
        {1'b0, 5'h02, 8'h00, 8'h32, 4'd5}, {1'b0, 5'h06, 8'h00, 8'h36, 4'd6}, // R5 live, R6 order
        {1'b0, 5'h1F, 8'h00, 8'h00, 4'd6}, {1'b0, 5'h07, 8'h00, 8'h00, 4'd6}, // R6 unmapped
        {1'b0, 5'h11, 8'h00, 8'h01, 4'd3}                                     // R3 running
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        @(negedge clk); bus_addr = a; #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    localparam logic [55:0] TA = 56'h06_12_11_25_17_45_30;
    localparam logic [55:0] TB = 56'h06_12_11_25_17_46_31;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1", 5'h10, 8'h00);
        rd_chk("R1", 5'h11, 8'h01);
        rd_chk("R1", 5'h12, 8'h00);
        chk("R1", {7'd0, alarm_irq}, 8'h00);
        wr(5'h10, 8'h80);
        rd_chk("R1", 5'h03, 8'h00);
        wr(5'h10, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][25]) wr(VEC[i][24:20], VEC[i][19:12]);
            else rd_chk($sformatf("R%0d", VEC[i][3:0]), VEC[i][24:20], VEC[i][11:4]);
        end

        // R4 / R5 snapshot
        live_time = TA;
        wr(5'h10, 8'hC0);
        rd_chk("R4", 5'h00, 8'h00);
        pulse_tick();
        rd_chk("R4", 5'h00, 8'h30);
        live_time = TB;
        rd_chk("R5", 5'h01, 8'h45);
        pulse_tick();
        rd_chk("R4", 5'h00, 8'h30);
        wr(5'h10, 8'h40);
        rd_chk("R5", 5'h00, 8'h31);
        wr(5'h10, 8'h80);
        pulse_tick();
        wr(5'h10, 8'hC0);
        pulse_tick();
        rd_chk("R4", 5'h00, 8'h31);
        rd_chk("R4", 5'h06, 8'h06);
        wr(5'h10, 8'h00);

        // R6 time write forwarding
        @(negedge clk); bus_wr = 1'b1; bus_addr = 5'h03; bus_wdata = 8'h15; #1;
        chk("R6", {4'd0, cal_wr_en, cal_wr_idx}, 8'h0B);
        chk("R6", cal_wr_data, 8'h15);
        bus_addr = 5'h08; #1;
        chk("R6", {7'd0, cal_wr_en}, 8'h00);
        @(negedge clk); bus_wr = 1'b0;

        // R3 stop
        wr(5'h10, 8'h01);
        chk("R3", {7'd0, cal_run}, 8'h00);
        rd_chk("R3", 5'h11, 8'h00);
        wr(5'h10, 8'h00);
        chk("R3", {7'd0, cal_run}, 8'h01);

        // R7 / R8 / R9 alarm
        live_time = TA;
        for (int i = 0; i < 6; i++) wr(5'h08 + 5'(i), TA[i*8 +: 8]);
        rd_chk("R7", 5'h11, 8'h01);
        pulse_tick();
        rd_chk("R7", 5'h11, 8'h41);
        chk("R9", {7'd0, alarm_irq}, 8'h00);
        wr(5'h12, 8'h08);
        chk("R9", {7'd0, alarm_irq}, 8'h01);
        wr(5'h11, 8'h01);
        rd_chk("R8", 5'h11, 8'h41);
        wr(5'h11, 8'hFE);
        rd_chk("R8", 5'h11, 8'h01);
        chk("R9", {7'd0, alarm_irq}, 8'h00);
        live_time = {8'h03, TA[47:0]};
        pulse_tick();
        rd_chk("R7", 5'h11, 8'h41);
        wr(5'h11, 8'h40);
        live_time = {TA[55:48], 8'h13, TA[39:0]};
        pulse_tick();
        rd_chk("R7", 5'h11, 8'h01);
        live_time = TA;
        wr(5'h10, 8'h01);
        pulse_tick();
        rd_chk("R3", 5'h11, 8'h00);
        wr(5'h10, 8'h00);
        pulse_tick();
        @(negedge clk); tick = 1'b1; bus_wr = 1'b1; bus_addr = 5'h11; bus_wdata = 8'h40;
        @(negedge clk); tick = 1'b0; bus_wr = 1'b0;
        rd_chk("R8", 5'h11, 8'h41);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule